// File: doc/BRIEF.md
# Register-Mapped SPI Master with Burst Read

This block is an SPI master that a host drives through a small synchronous register bus. The bus has a 4-bit byte offset, separate read and write strobes, 16-bit write and read data, and a wait line. The host holds its strobe, address and data until it samples wait low. The access completes on that clock edge, and read data is valid in the same cycle. The SPI side drives a serial clock, a data-out line and four active-low chip selects, and it samples a data-in line. Each transfer is 16 bits, full duplex, MSB first, with no clock phase option.

One control register sets the clock divider, the idle clock level, which slave is addressed and a manual chip-select enable. Three data offsets start transfers. The offset used decides what happens to the chip select afterwards: one keeps it asserted, one releases it, and one keeps it asserted while it starts a speculative read. That last offset suits read bursts. After the first read, each following read picks up a word that was already fetched in the background. A status offset always returns the last word received.

Top module: `spi_burst_master`

## Requirements
- R1: Offset 0x0 read returns bit 15 = live `spi_miso`, bit 14 = idle-level select, bits 13:10 = divider low bits, bits 9:8 = slave select, bit 7 = chip-select enable, bit 0 = divider bit 4, and bits 6:1 = 0. Writes load every field except bit 15. After reset, all stored fields are 0.
- R2: The divider value D is {bit 0, bits 13:10}. With D = 0, one bit moves per base clock, and a data access that starts a transfer waits 17 cycles. With D > 0, each half period of `spi_sclk` lasts D base clocks, and such an access waits 32·D+1 cycles.
- R3: With D > 0 and no transfer running, `spi_sclk` rests at the idle-level bit (0 = low, 1 = high). With D = 0 it rests low.
- R4: Data moves MSB first. MOSI changes only on the trailing clock edge and is stable at each leading edge. The word the slave returns is assembled from 16 leading-edge samples.
- R5: Offset 0x8 runs one transfer: a write sends its data, a read returns the received word. The chip select stays asserted afterwards, and bit 7 reads 1.
- R6: Offset 0xC runs one transfer and then deasserts every chip select, clearing bit 7.
- R7: Offset 0x2 returns the word received by the most recent completed transfer, prefetches included, and completes without wait.
- R8: A read of 0xA returns a received word and at once starts another zero-data transfer with the chip select held. A later read of 0xA or 0x8 collects that prefetched word with no new transfer, and without wait if the prefetch has finished. A collecting read of 0xA starts the next prefetch.
- R9: `bus_wait` is high only for accesses to 0x8, 0xC or a read of 0xA. It is held until the access's own transfer finishes, or a prefetch in progress finishes. All other accesses complete with no wait.
- R10: Offsets 0x4, 0x6 and 0xE, and writes to 0xA, read back 0 (where readable). They change no register and start no transfer.
- R11: At most one chip select is low. The select field is applied only while the chip select is deasserted: a change made while it is asserted takes effect at its next assertion.
- R12: A transfer started by a read (0x8, 0xA or 0xC) or by a prefetch sends 16 zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the register |
| bus_rd | input | 1 | Read strobe, held until wait is low |
| bus_wr | input | 1 | Write strobe, held until wait is low |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid when wait is low |
| bus_wait | output | 1 | Stall the current access |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
A wrong host state shows in two ways. A word lands on the wrong access, either a stale prefetch or a missing one. Or the slave counts an extra or missing frame, or `bus_wait` lasts a different number of cycles. Any of these is visible within one transfer time. A bad bit count or a wrong edge choice in the shifter corrupts the word the slave model captures at the very next frame boundary. Wrong chip-select latching shows up as the wrong select line low on the first frame after a select change.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
package spi_burst_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned SEL_W  = 2;
    localparam int unsigned NUM_CS = 1 << SEL_W;
    localparam int unsigned DIV_W  = 5;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_LAST = 4'h2;
    localparam logic [ADDR_W-1:0] OFF_HOLD = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_PIPE = 4'hA;
    localparam logic [ADDR_W-1:0] OFF_DROP = 4'hC;

    typedef enum logic [1:0] {
        H_IDLE,
        H_XFER,
        H_PREF,
        H_PRDY
    } host_st_e;

    typedef struct packed {
        host_st_e           st;
        logic               cpol;
        logic [DIV_W-1:0]   speed;
        logic [SEL_W-1:0]   sel;
        logic               cs_en;
        logic               rel;
        logic               pipe;
        logic [WORD_W-1:0]  last;
        logic [WORD_W-1:0]  pf;
    } host_t;

    localparam host_t HOST_RST = '{
        st:    H_IDLE,
        cpol:  1'b0,
        speed: '0,
        sel:   '0,
        cs_en: 1'b0,
        rel:   1'b0,
        pipe:  1'b0,
        last:  '0,
        pf:    '0
    };

endpackage

// File: rtl/spi_edge_gen.sv
`timescale 1ns/1ps
module spi_edge_gen #(
    parameter int unsigned DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] speed_i,
    output logic             step_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } gen_t;

    gen_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        step_o = 1'b0;
        if (!run_i) begin
            s_d.div = '0;
        end else if (speed_i == '0) begin
            step_o = 1'b1;
        end else if (s_q.div == speed_i - 1'b1) begin
            step_o  = 1'b1;
            s_d.div = '0;
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2
    step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && speed_i > 1 && step_o) |=> (!step_o || speed_i != $past(speed_i)));

endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
module spi_shift_core #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] tx_i,
    input  logic         cpol_i,
    input  logic         fast_i,
    input  logic         step_i,
    input  logic         miso_i,
    output logic         run_o,
    output logic         done_o,
    output logic [W-1:0] rx_o,
    output logic         mosi_o,
    output logic         sclk_o
);

    localparam int unsigned CNT_W = $clog2(2 * W);
    localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(2 * W - 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic             sclk;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sh;
        logic [W-1:0]     rx;
    } core_t;

    core_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.run) begin
            s_d.sclk = cpol_i;
            if (start_i) begin
                s_d.run = 1'b1;
                s_d.sh  = tx_i;
                s_d.rx  = '0;
                s_d.cnt = '0;
            end
        end else if (step_i) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (fast_i) begin
                s_d.rx = {s_q.rx[W-2:0], miso_i};
                s_d.sh = {s_q.sh[W-2:0], 1'b0};
                if (s_q.cnt == LAST_FAST) begin
                    s_d.run  = 1'b0;
                    s_d.done = 1'b1;
                end
            end else begin
                s_d.sclk = ~s_q.sclk;
                if (!s_q.cnt[0]) s_d.rx = {s_q.rx[W-2:0], miso_i};
                else             s_d.sh = {s_q.sh[W-2:0], 1'b0};
                if (s_q.cnt == LAST_HALF) begin
                    s_d.run  = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run_o  = s_q.run;
    assign done_o = s_q.done;
    assign rx_o   = s_q.rx;
    assign mosi_o = s_q.sh[W-1];
    assign sclk_o = s_q.sclk;

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !s_q.run);

    // R4
    mosi_lead_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !fast_i && step_i && !s_q.cnt[0]) |=> $stable(mosi_o));

endmodule

// File: rtl/spi_cs_decode.sv
`timescale 1ns/1ps
module spi_cs_decode #(
    parameter int unsigned SEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_q_i,
    input  logic [SEL_W-1:0]        sel_d_i,
    output logic [(1<<SEL_W)-1:0]   cs_n_o
);

    localparam int unsigned NCS = 1 << SEL_W;

    logic [SEL_W-1:0] act_d, act_q;

    always_comb begin
        act_d = en_q_i ? act_q : sel_d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n_o[i] = !(en_q_i && act_q == SEL_W'(i));
    end

    // R11
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R11
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q_i && $past(en_q_i)) |-> $stable(cs_n_o));

endmodule

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master
    import spi_burst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        bus_wait,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic [3:0]  spi_cs_n
);

    host_t h_d, h_q;

    logic              core_start;
    logic [WORD_W-1:0] core_tx;
    logic              core_run;
    logic              core_done;
    logic [WORD_W-1:0] core_rx;
    logic              core_sclk;
    logic              core_step;
    logic              fast_mode;
    logic              strobe;
    logic              data_acc;
    logic              collect;
    logic [WORD_W-1:0] ctrl_view;
    logic              unused_rsvd_bits;

    assign unused_rsvd_bits = ^bus_wdata[6:1];

    assign fast_mode = (h_q.speed == '0);
    assign strobe    = bus_rd | bus_wr;
    assign data_acc  = strobe && ((bus_addr == OFF_HOLD) || (bus_addr == OFF_DROP) ||
                                  (bus_addr == OFF_PIPE && bus_rd));
    assign collect   = bus_rd && ((bus_addr == OFF_HOLD) || (bus_addr == OFF_PIPE));
    assign ctrl_view = {spi_miso, h_q.cpol, h_q.speed[3:0], h_q.sel, h_q.cs_en,
                        6'b0, h_q.speed[4]};

    always_comb begin
        h_d        = h_q;
        core_start = 1'b0;
        core_tx    = '0;
        bus_wait   = 1'b0;
        bus_rdata  = '0;

        if (core_done) h_d.last = core_rx;

        if (bus_wr && bus_addr == OFF_CTRL) begin
            h_d.cpol  = bus_wdata[14];
            h_d.speed = {bus_wdata[0], bus_wdata[13:10]};
            h_d.sel   = bus_wdata[9:8];
            h_d.cs_en = bus_wdata[7];
        end

        case (bus_addr)
            OFF_CTRL: bus_rdata = ctrl_view;
            OFF_LAST: bus_rdata = h_q.last;
            default:  bus_rdata = '0;
        endcase

        case (h_q.st)
            H_IDLE: begin
                if (data_acc) begin
                    bus_wait   = 1'b1;
                    core_start = 1'b1;
                    core_tx    = bus_wr ? bus_wdata : '0;
                    h_d.st     = H_XFER;
                    h_d.rel    = (bus_addr == OFF_DROP);
                    h_d.pipe   = (bus_addr == OFF_PIPE) && bus_rd;
                    h_d.cs_en  = 1'b1;
                end
            end
            H_XFER: begin
                if (data_acc) begin
                    bus_wait = !core_done;
                    if (core_done && bus_rd) bus_rdata = core_rx;
                end
                if (core_done) begin
                    if (h_q.rel) h_d.cs_en = 1'b0;
                    if (h_q.pipe) begin
                        core_start = 1'b1;
                        h_d.st     = H_PREF;
                    end else begin
                        h_d.st = H_IDLE;
                    end
                end
            end
            H_PREF: begin
                if (data_acc) bus_wait = 1'b1;
                if (core_done) begin
                    h_d.pf = core_rx;
                    h_d.st = H_PRDY;
                end
            end
            H_PRDY: begin
                if (data_acc) begin
                    if (collect) begin
                        bus_rdata = h_q.pf;
                        if (bus_addr == OFF_PIPE) begin
                            core_start = 1'b1;
                            h_d.st     = H_PREF;
                        end else begin
                            h_d.st = H_IDLE;
                        end
                    end else begin
                        bus_wait   = 1'b1;
                        core_start = 1'b1;
                        core_tx    = bus_wr ? bus_wdata : '0;
                        h_d.st     = H_XFER;
                        h_d.rel    = (bus_addr == OFF_DROP);
                        h_d.pipe   = 1'b0;
                        h_d.cs_en  = 1'b1;
                    end
                end
            end
            default: h_d.st = H_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= HOST_RST;
        else        h_q <= h_d;
    end

    spi_edge_gen #(
        .DIV_W (DIV_W)
    ) i_edge_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (core_run),
        .speed_i (h_q.speed),
        .step_o  (core_step)
    );

    spi_shift_core #(
        .W (WORD_W)
    ) i_shift_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (core_start),
        .tx_i    (core_tx),
        .cpol_i  (h_q.cpol),
        .fast_i  (fast_mode),
        .step_i  (core_step),
        .miso_i  (spi_miso),
        .run_o   (core_run),
        .done_o  (core_done),
        .rx_o    (core_rx),
        .mosi_o  (spi_mosi),
        .sclk_o  (core_sclk)
    );

    spi_cs_decode #(
        .SEL_W (SEL_W)
    ) i_cs_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_q_i  (h_q.cs_en),
        .sel_d_i (h_d.sel),
        .cs_n_o  (spi_cs_n)
    );

    assign spi_sclk = fast_mode ? (core_run & ~clk) : core_sclk;

    // R8
    prefetch_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.st == H_PRDY) |-> !core_run);

    // R9
    wait_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> data_acc);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_run && $past(!core_run) && h_q.speed != '0 && $stable(h_q.cpol))
            |-> (spi_sclk == h_q.cpol));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.st == H_XFER && h_q.rel && core_done) |=> (&spi_cs_n));

endmodule

// File: tb/test_spi_burst_master.sv
`timescale 1ns/1ps
module test_spi_burst_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_wait;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso;
    logic [3:0]  spi_cs_n;

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [17:0] exp_q[$];
    int          exp_frame = 0;
    int          slv_frame = 0;
    int          slv_bits  = 0;
    logic [15:0] slv_cap   = '0;
    logic        miso_r    = 1'b0;
    int          cfg_speed = 0;
    logic        cfg_cpol  = 1'b0;

    assign spi_miso = miso_r;
    wire cs_act = ~&spi_cs_n;

    spi_burst_master i_spi_burst_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_wait  (bus_wait),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n)
    );

    function automatic logic [15:0] pat(int n);
        return 16'h9A5C ^ 16'(n * 4951 + n);
    endfunction

    function automatic logic slv_bit(int fr, int b);
        logic [15:0] w;
        w = pat(fr);
        return w[15-b];
    endfunction

    function automatic logic [1:0] low_idx(logic [3:0] cs);
        logic [1:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) if (!cs[i]) r = 2'(i);
        return r;
    endfunction

    function automatic logic idle_lvl();
        return (cfg_speed == 0) ? 1'b0 : cfg_cpol;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: slave model captures each frame and pops the expectation.
    always @(posedge cs_act) begin
        slv_bits = 0;
        #1 miso_r = slv_bit(slv_frame, 0);
    end

    always @(spi_sclk) begin
        if (cs_act) begin
            if (spi_sclk !== idle_lvl()) begin
                slv_cap = {slv_cap[14:0], spi_mosi};
                slv_bits++;
                if (slv_bits == 16) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        fails++;
                        $display("FAIL R4 actual=%h expected=none (unexpected frame)", slv_cap);
                    end else begin
                        logic [17:0] e;
                        e = exp_q.pop_front();
                        if ({low_idx(spi_cs_n), slv_cap} !== e) begin
                            fails++;
                            $display("FAIL R4 actual=%h expected=%h", {low_idx(spi_cs_n), slv_cap}, e);
                        end
                    end
                    slv_bits = 0;
                    slv_frame++;
                end
            end else begin
                #1 miso_r = slv_bit(slv_frame, slv_bits);
            end
        end
    end

    // Driver: pushes the expected frame, returns the received word it predicts.
    function automatic logic [15:0] push_frame(logic [1:0] lun, logic [15:0] w);
        exp_q.push_back({lun, w});
        exp_frame++;
        return pat(exp_frame - 1);
    endfunction

    task automatic bus_access(input logic rd, input logic [3:0] addr, input logic [15:0] wd,
                              output logic [15:0] rdat, output int waits);
        @(negedge clk);
        bus_addr  = addr;
        bus_rd    = rd;
        bus_wr    = !rd;
        bus_wdata = wd;
        waits     = 0;
        #1;
        while (bus_wait) begin
            waits++;
            @(negedge clk);
            #1;
        end
        rdat = bus_rdata;
        @(posedge clk);
        #1;
        bus_rd = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic wr_ctrl(input logic cpol, input int speed, input logic [1:0] sel, input logic cs);
        logic [15:0] v;
        logic [15:0] d;
        int w;
        v = {1'b0, cpol, 4'(speed), sel, cs, 6'b0, 1'(speed >> 4)};
        bus_access(1'b0, 4'h0, v, d, w);
        cfg_cpol  = cpol;
        cfg_speed = speed;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] rd;
        logic [15:0] e;
        logic [15:0] pf;
        int w;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset cs", 32'(spi_cs_n), 32'hF);
        check("R3 reset sclk", 32'(spi_sclk), 32'h0);
        check("R9 reset wait", 32'(bus_wait), 32'h0);
        bus_access(1'b1, 4'h0, '0, rd, w);
        check("R1 reset ctrl", 32'(rd), 32'h0);

        // R1 field layout, speed 19, select 2, idle high
        bus_access(1'b0, 4'h0, 16'h4E01 | 16'h0200, rd, w);
        bus_access(1'b1, 4'h0, '0, rd, w);
        check("R1 ctrl readback", 32'(rd), 32'h4E01 | 32'h0200);
        miso_r = 1'b1;
        bus_access(1'b1, 4'h0, '0, rd, w);
        check("R1 live miso bit", 32'(rd), 32'hCE01 | 32'h0200);
        miso_r = 1'b0;

        // R10 reserved offsets and writes to the pipelined offset
        bus_access(1'b0, 4'h4, 16'hFFFF, rd, w);
        bus_access(1'b0, 4'hA, 16'h1234, rd, w);
        check("R9 no wait on 0xA write", 32'(w), 32'h0);
        bus_access(1'b1, 4'hE, '0, rd, w);
        check("R10 reserved reads zero", 32'(rd), 32'h0);
        bus_access(1'b1, 4'h0, '0, rd, w);
        check("R10 ctrl untouched", 32'(rd), 32'h4E01 | 32'h0200);
        check("R10 no frame started", 32'(slv_frame), 32'h0);

        // R2 R5 fast mode write on select 1
        wr_ctrl(1'b0, 0, 2'd1, 1'b0);
        e = push_frame(2'd1, 16'hC3A5);
        bus_access(1'b0, 4'h8, 16'hC3A5, rd, w);
        check("R2 fast wait cycles", 32'(w), 32'd17);
        check("R5 cs held after 0x8", 32'(spi_cs_n), 32'hD);
        bus_access(1'b1, 4'h2, '0, rd, w);
        check("R7 last word", 32'(rd), 32'(e));
        check("R9 status no wait", 32'(w), 32'h0);

        // R12 R5 read of 0x8 sends zeros and returns data
        e = push_frame(2'd1, 16'h0000);
        bus_access(1'b1, 4'h8, '0, rd, w);
        check("R5 read data", 32'(rd), 32'(e));

        // R11 select change while asserted is deferred
        wr_ctrl(1'b0, 0, 2'd3, 1'b1);
        @(negedge clk);
        check("R11 select frozen", 32'(spi_cs_n), 32'hD);
        e = push_frame(2'd1, 16'h5A0F);
        bus_access(1'b0, 4'hC, 16'h5A0F, rd, w);
        @(negedge clk);
        check("R6 cs released", 32'(spi_cs_n), 32'hF);
        bus_access(1'b1, 4'h0, '0, rd, w);
        check("R6 enable bit cleared", 32'(rd[7]), 32'h0);
        e = push_frame(2'd3, 16'h1111);
        bus_access(1'b0, 4'h8, 16'h1111, rd, w);
        check("R11 new select applied", 32'(spi_cs_n), 32'h7);

        // R3 idle levels
        wr_ctrl(1'b1, 0, 2'd0, 1'b0);
        repeat (2) @(negedge clk);
        check("R3 fast idles low", 32'(spi_sclk), 32'h0);
        wr_ctrl(1'b1, 2, 2'd0, 1'b0);
        repeat (2) @(negedge clk);
        check("R3 idle high", 32'(spi_sclk), 32'h1);

        // R2 R6 divided clock, idle high
        e = push_frame(2'd0, 16'h8001);
        bus_access(1'b0, 4'hC, 16'h8001, rd, w);
        check("R2 divide 2 wait", 32'(w), 32'd65);
        @(negedge clk);
        check("R6 cs released div", 32'(spi_cs_n), 32'hF);
        bus_access(1'b1, 4'h2, '0, rd, w);
        check("R7 last word div", 32'(rd), 32'(e));

        // R12 read of 0xC at divide 1
        wr_ctrl(1'b0, 1, 2'd0, 1'b0);
        e = push_frame(2'd0, 16'h0000);
        bus_access(1'b1, 4'hC, '0, rd, w);
        check("R2 divide 1 wait", 32'(w), 32'd33);
        check("R12 0xC read data", 32'(rd), 32'(e));

        // R8 burst on select 2 at divide 3
        wr_ctrl(1'b0, 3, 2'd2, 1'b0);
        e  = push_frame(2'd2, 16'h0000);
        pf = push_frame(2'd2, 16'h0000);
        bus_access(1'b1, 4'hA, '0, rd, w);
        check("R2 divide 3 wait", 32'(w), 32'd97);
        check("R8 first burst word", 32'(rd), 32'(e));
        repeat (120) @(negedge clk);
        e  = pf;
        pf = push_frame(2'd2, 16'h0000);
        bus_access(1'b1, 4'hA, '0, rd, w);
        check("R8 prefetched no wait", 32'(w), 32'h0);
        check("R8 prefetched word", 32'(rd), 32'(e));
        e  = pf;
        pf = push_frame(2'd2, 16'h0000);
        bus_access(1'b1, 4'hA, '0, rd, w);
        check("R9 stall on running prefetch", 32'(w > 0), 32'h1);
        check("R8 word after stall", 32'(rd), 32'(e));
        repeat (120) @(negedge clk);
        bus_access(1'b1, 4'h8, '0, rd, w);
        check("R8 0x8 collects no wait", 32'(w), 32'h0);
        check("R8 0x8 collect word", 32'(rd), 32'(pf));
        bus_access(1'b1, 4'h2, '0, rd, w);
        check("R7 last word prefetch", 32'(rd), 32'(pf));
        repeat (150) @(negedge clk);
        check("R8 no extra frame", 32'(slv_frame), 32'(exp_frame));
        check("R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
        check("R5 cs still held", 32'(spi_cs_n), 32'hB);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule